// File: doc/BRIEF.md
# Multi-Context Address Translation Unit

This block turns virtual addresses from a heavily threaded accelerator into physical addresses. Every request names one of four address spaces with a 2-bit identifier. All four spaces are live at the same time, and each has its own page-table base. Requests from different processes can therefore interleave cycle by cycle with no flush on a switch. Translations are cached in a small, fully associative array. Each entry is tagged by space, virtual page and mapping size. A miss starts a hardware walker, which fetches 64-bit descriptors over a simple read port.

The walker resolves 4 KB pages and also 2 MB and 1 GB blocks. A block occupies a single cached entry. Every translation returns a cacheable flag and a shared (host-coherent) flag. An unmapped or out-of-range address returns a fault that carries the address space and the virtual address. An invalidate input clears the cached translations of one address space and leaves the other spaces untouched.

Top module: `mctx_xlate`

## Requirements
- R1: After reset, reqReady is 1, rspValid and memReqValid are 0, and the cache holds no entry, so the first request to any space walks the tables.
- R2: A request with any of reqVa bits 63:48 set gets a fault response in the cycle after acceptance. It makes no memory read, and this holds even when the low 48 bits would hit in the cache.
- R3: The walk has four levels. The indices come from VA bits 47:39, 38:30, 29:21 and 20:12. Each descriptor is read at {table[47:12], index, 3'b000}. The level-1 table is tableBase[asid*48 +: 48], and each deeper table is the descriptor's bits 47:12 followed by 12 zero bits.
- R4: Descriptor bits 1:0 = 11 at level 4 is a 4 KB page. The result is PA = {desc[47:12], va[11:0]}, with cacheable = desc[2] and shared = desc[3].
- R5: Descriptor bits 1:0 = 01 is a 1 GB block at level 2, giving PA = {desc[47:30], va[29:0]}. At level 3 it is a 2 MB block, giving PA = {desc[47:21], va[20:0]}. Bits 1:0 = 11 at levels 1 to 3 points to the next table.
- R6: Bits 1:0 = 00 or 10 at any level, and 01 at level 1 or level 4, end the walk with rspFault = 1. The fault response has rspPa = 0 and both attributes 0, and it echoes the request's asid and full VA.
- R7: A request that hits in the cache responds in the cycle after acceptance, with no memory read.
- R8: The same VA in different address spaces translates through that space's own tables. Requests may alternate between spaces back to back, and each keeps its own cached result.
- R9: A cached block entry covers its whole block: any VA inside a cached 2 MB or 1 GB block hits.
- R10: An invalidate pulse (invValid with invAsid) clears only the entries of that space, taking effect from the next cycle. Entries of the other spaces still hit.
- R11: The cache holds 8 entries, and fills replace them in round-robin order. After 8 fills in one space, a ninth fill evicts the oldest entry, while the second-oldest still hits.
- R12: A miss holds reqReady at 0 from the cycle after acceptance until its response. Only one walk is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Unit can accept a request this cycle |
| reqAsid | input | 2 | Address-space identifier of the request |
| reqVa | input | 64 | Virtual address |
| tableBase | input | 192 | Four 48-bit level-1 table bases, space n at bits n*48 +: 48 |
| invValid | input | 1 | Invalidate pulse |
| invAsid | input | 2 | Space whose cached entries are cleared |
| memReqValid | output | 1 | Descriptor read strobe (one cycle) |
| memReqAddr | output | 48 | Descriptor address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | 64 | Descriptor |
| rspValid | output | 1 | Response valid (one cycle) |
| rspAsid | output | 2 | Space of the answered request |
| rspVa | output | 64 | Virtual address of the answered request |
| rspPa | output | 48 | Physical address (0 on fault) |
| rspCacheable | output | 1 | Cacheable attribute |
| rspShared | output | 1 | Host-coherent attribute |
| rspFault | output | 1 | Translation fault |

## Verification
Four families of access patterns are driven. The first is a cold access to a page, a 1 GB block and a 2 MB block, and the number of descriptor reads (4, 2, 3) tells apart the depth at which each walk stops. The second repeats accesses inside a page or block and alternates spaces on one VA, which separates hits from misses and exposes any sharing of entries between spaces. The third uses descriptors that are malformed at each level, plus high-bit addresses, which shows whether a fault is raised at the right level or before any read. The fourth is a nine-page sweep and a per-space invalidate, which shows whether the victim chosen is the oldest entry and whether only the named space is cleared.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {DK_BAD, DK_TABLE, DK_LEAF} descKind_t;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} walkState_t;

  typedef struct packed {
    logic cap;
    logic nextLvl;
    logic fill;
    logic rspHit;
    logic rspLeaf;
    logic rspWalkFault;
    logic rspEarlyFault;
  } xlStrobe_t;
endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int TLB_N   = 8,
  parameter int VA_W    = 64,
  parameter int MAP_W   = 48,
  parameter int PA_W    = 48,
  parameter int DESC_W  = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xlStrobe_t                 stb,
  input  logic [$clog2(NUM_CTX)-1:0] reqAsid,
  input  logic [VA_W-1:0]           reqVa,
  input  logic [NUM_CTX*PA_W-1:0]   tableBase,
  input  logic                      invValid,
  input  logic [$clog2(NUM_CTX)-1:0] invAsid,
  input  logic [DESC_W-1:0]         memRspData,
  output logic                      hit,
  output logic                      badVa,
  output descKind_t                 kind,
  output logic [PA_W-1:0]           memReqAddr,
  output logic                      rspValid,
  output logic [$clog2(NUM_CTX)-1:0] rspAsid,
  output logic [VA_W-1:0]           rspVa,
  output logic [PA_W-1:0]           rspPa,
  output logic                      rspCacheable,
  output logic                      rspShared,
  output logic                      rspFault
);
  localparam int PG    = 12;
  localparam int IDX_W = 9;
  localparam int CTX_W = $clog2(NUM_CTX);
  localparam int RR_W  = $clog2(TLB_N);

  function automatic logic [VA_W-1:0] offMask(input logic [1:0] sz);
    logic [VA_W-1:0] one;
    one = VA_W'(1);
    return (one << (PG + IDX_W * int'(sz))) - one;
  endfunction

  // translation cache storage
  logic [TLB_N-1:0]      tValid;
  logic [CTX_W-1:0]      tAsid [TLB_N];
  logic [MAP_W-1:PG]     tVpn  [TLB_N];
  logic [1:0]            tSize [TLB_N];
  logic [PA_W-1:0]       tPa   [TLB_N];
  logic                  tC    [TLB_N];
  logic                  tS    [TLB_N];
  logic [RR_W-1:0]       rr;
  logic [TLB_N-1:0]      hitVec;

  // walk state
  logic [CTX_W-1:0]      curAsid;
  logic [VA_W-1:0]       curVa;
  logic [1:0]            lvl;
  logic [PA_W-1:0]       tblAddr;

  assign badVa = |reqVa[VA_W-1:MAP_W];

  for (genvar g = 0; g < TLB_N; g++) begin : gMatch
    logic [VA_W-1:0] m;
    assign m = offMask(tSize[g]);
    assign hitVec[g] = tValid[g] && (tAsid[g] == reqAsid) &&
                       (((reqVa[MAP_W-1:PG] ^ tVpn[g]) & ~m[MAP_W-1:PG]) == '0);
  end
  assign hit = |hitVec;

  logic [PA_W-1:0] hitPa;
  logic            hitC, hitS;
  always_comb begin
    logic [VA_W-1:0] hm;
    hm    = '0;
    hitPa = '0;
    hitC  = 1'b0;
    hitS  = 1'b0;
    for (int i = 0; i < TLB_N; i++) begin
      if (hitVec[i]) begin
        hm    = offMask(tSize[i]);
        hitPa = (tPa[i] & ~hm[PA_W-1:0]) | (reqVa[PA_W-1:0] & hm[PA_W-1:0]);
        hitC  = tC[i];
        hitS  = tS[i];
      end
    end
  end

  // descriptor address and decode
  int                 idxLsb;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         leafSz;
  logic [VA_W-1:0]    leafMask;
  logic [PA_W-1:0]    descPa;
  logic [PA_W-1:0]    leafPa;

  always_comb begin
    idxLsb     = MAP_W - IDX_W * (int'(lvl) + 1);
    idx        = curVa[idxLsb +: IDX_W];
    memReqAddr = {tblAddr[PA_W-1:PG], idx, 3'b000};
    leafSz     = 2'd3 - lvl;
    leafMask   = offMask(leafSz);
    descPa     = {memRspData[PA_W-1:PG], {PG{1'b0}}};
    leafPa     = (descPa & ~leafMask[PA_W-1:0]) | (curVa[PA_W-1:0] & leafMask[PA_W-1:0]);
    case (lvl)
      2'd0:    kind = (memRspData[1:0] == 2'b11) ? DK_TABLE : DK_BAD;
      2'd3:    kind = (memRspData[1:0] == 2'b11) ? DK_LEAF  : DK_BAD;
      default: kind = (memRspData[1:0] == 2'b11) ? DK_TABLE :
                      (memRspData[1:0] == 2'b01) ? DK_LEAF  : DK_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAsid <= '0;
      curVa   <= '0;
      lvl     <= '0;
      tblAddr <= '0;
    end else if (stb.cap) begin
      curAsid <= reqAsid;
      curVa   <= reqVa;
      lvl     <= '0;
      tblAddr <= tableBase[int'(reqAsid)*PA_W +: PA_W];
    end else if (stb.nextLvl) begin
      lvl     <= lvl + 2'd1;
      tblAddr <= descPa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tValid <= '0;
      rr     <= '0;
    end else begin
      if (stb.fill) begin
        tValid[rr] <= 1'b1;
        tAsid[rr]  <= curAsid;
        tVpn[rr]   <= curVa[MAP_W-1:PG];
        tSize[rr]  <= leafSz;
        tPa[rr]    <= descPa & ~leafMask[PA_W-1:0];
        tC[rr]     <= memRspData[2];
        tS[rr]     <= memRspData[3];
        rr         <= rr + RR_W'(1);
      end
      if (invValid) begin
        for (int i = 0; i < TLB_N; i++) begin
          if (tAsid[i] == invAsid) tValid[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAsid      <= '0;
      rspVa        <= '0;
      rspPa        <= '0;
      rspCacheable <= 1'b0;
      rspShared    <= 1'b0;
      rspFault     <= 1'b0;
    end else begin
      rspValid     <= stb.rspHit | stb.rspLeaf | stb.rspWalkFault | stb.rspEarlyFault;
      rspPa        <= '0;
      rspCacheable <= 1'b0;
      rspShared    <= 1'b0;
      rspFault     <= stb.rspWalkFault | stb.rspEarlyFault;
      if (stb.rspHit || stb.rspEarlyFault) begin
        rspAsid <= reqAsid;
        rspVa   <= reqVa;
      end else begin
        rspAsid <= curAsid;
        rspVa   <= curVa;
      end
      if (stb.rspHit) begin
        rspPa        <= hitPa;
        rspCacheable <= hitC;
        rspShared    <= hitS;
      end else if (stb.rspLeaf) begin
        rspPa        <= leafPa;
        rspCacheable <= memRspData[2];
        rspShared    <= memRspData[3];
      end
    end
  end

  // R9 / R11: fills only follow misses, so at most one entry may match
  assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  for (genvar g = 0; g < TLB_N; g++) begin : gInvChk
    // R10: an entry of the invalidated space is gone in the next cycle
    assert_inv_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      (invValid && tAsid[g] == invAsid) |=> !tValid[g]);
  end
endmodule

// File: rtl/xlate_ctl.sv
module xlate_ctl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      badVa,
  input  descKind_t kind,
  input  logic      memRspValid,
  output logic      reqReady,
  output logic      memReqValid,
  output xlStrobe_t stb
);
  walkState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (badVa)    stb.rspEarlyFault = 1'b1;
          else if (hit) stb.rspHit = 1'b1;
          else begin
            stb.cap   = 1'b1;
            nextState = S_ISSUE;
          end
        end
      end
      S_ISSUE: nextState = S_WAIT;
      S_WAIT: begin
        if (memRspValid) begin
          case (kind)
            DK_TABLE: begin
              stb.nextLvl = 1'b1;
              nextState   = S_ISSUE;
            end
            DK_LEAF: begin
              stb.fill    = 1'b1;
              stb.rspLeaf = 1'b1;
              nextState   = S_IDLE;
            end
            default: begin
              stb.rspWalkFault = 1'b1;
              nextState        = S_IDLE;
            end
          endcase
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);

  // R3: a table descriptor always leads to another descriptor read
  assert_table_reads_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && memRspValid && kind == DK_TABLE) |=> memReqValid);
endmodule

// File: rtl/mctx_xlate.sv
module mctx_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int TLB_N   = 8,
  parameter int VA_W    = 64,
  parameter int MAP_W   = 48,
  parameter int PA_W    = 48,
  parameter int DESC_W  = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [$clog2(NUM_CTX)-1:0] reqAsid,
  input  logic [VA_W-1:0]            reqVa,
  input  logic [NUM_CTX*PA_W-1:0]    tableBase,
  input  logic                       invValid,
  input  logic [$clog2(NUM_CTX)-1:0] invAsid,
  output logic                       memReqValid,
  output logic [PA_W-1:0]            memReqAddr,
  input  logic                       memRspValid,
  input  logic [DESC_W-1:0]          memRspData,
  output logic                       rspValid,
  output logic [$clog2(NUM_CTX)-1:0] rspAsid,
  output logic [VA_W-1:0]            rspVa,
  output logic [PA_W-1:0]            rspPa,
  output logic                       rspCacheable,
  output logic                       rspShared,
  output logic                       rspFault
);
  xlStrobe_t stb;
  logic      hit, badVa;
  descKind_t kind;

  xlate_ctl i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit), .badVa(badVa),
    .kind(kind), .memRspValid(memRspValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .stb(stb)
  );

  xlate_dp #(
    .NUM_CTX(NUM_CTX), .TLB_N(TLB_N), .VA_W(VA_W), .MAP_W(MAP_W),
    .PA_W(PA_W), .DESC_W(DESC_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAsid(reqAsid), .reqVa(reqVa),
    .tableBase(tableBase), .invValid(invValid), .invAsid(invAsid),
    .memRspData(memRspData), .hit(hit), .badVa(badVa), .kind(kind),
    .memReqAddr(memReqAddr), .rspValid(rspValid), .rspAsid(rspAsid),
    .rspVa(rspVa), .rspPa(rspPa), .rspCacheable(rspCacheable),
    .rspShared(rspShared), .rspFault(rspFault)
  );

  logic accepted, highBits;
  assign accepted = reqValid && reqReady;
  assign highBits = |reqVa[VA_W-1:MAP_W];

  // R2: out-of-range address faults at once, no read
  assert_early_fault_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && highBits) |=> (rspValid && rspFault && !memReqValid && reqReady));

  // R7: a hit answers in the next cycle
  assert_hit_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && hit && !highBits) |=> (rspValid && !rspFault && !memReqValid));

  // R12: a miss closes the request port and starts a read
  assert_miss_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !hit && !highBits) |=> (!reqReady && memReqValid && !rspValid));

  // R6: a fault carries no address and no attributes
  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPa == '0 && !rspCacheable && !rspShared));
endmodule

// File: tb/test_mctx_xlate.sv
`timescale 1ns/1ps
module test_mctx_xlate;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqReady;
  logic [1:0]  reqAsid = 0;
  logic [63:0] reqVa = 0;
  logic [191:0] tableBase;
  logic        invValid = 0;
  logic [1:0]  invAsid = 0;
  logic        memReqValid;
  logic [47:0] memReqAddr;
  logic        memRspValid = 0;
  logic [63:0] memRspData = 0;
  logic        rspValid;
  logic [1:0]  rspAsid;
  logic [63:0] rspVa;
  logic [47:0] rspPa;
  logic        rspCacheable, rspShared, rspFault;

  always #4 clk = ~clk;

  logic [47:0] base [4];
  initial begin
    base[0] = 48'h0000_0001_0000;
    base[1] = 48'h0000_0002_0000;
    base[2] = 48'h0000_0003_0000;
    base[3] = 48'h0000_0004_0000;
  end
  assign tableBase = {base[3], base[2], base[1], base[0]};

  mctx_xlate i_mctx_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAsid(reqAsid), .reqVa(reqVa), .tableBase(tableBase),
    .invValid(invValid), .invAsid(invAsid), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspAsid(rspAsid), .rspVa(rspVa), .rspPa(rspPa),
    .rspCacheable(rspCacheable), .rspShared(rspShared), .rspFault(rspFault)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [1:0]  asid;
    logic [63:0] va;
    logic [47:0] pa;
    logic        c, s, f;
    int          reads;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [63:0] mem [logic [47:0]];
  logic [47:0] nextTbl = 48'h0000_0010_0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // software model: build tables down to a leaf at level leafLvl
  task automatic mapLeaf(input logic [1:0] ctx, input logic [63:0] va, input logic [47:0] pa,
                         input logic c, input logic s, input int leafLvl, output logic [47:0] leafAddr);
    logic [47:0] tbl, a;
    logic [8:0]  idx;
    tbl = base[ctx];
    leafAddr = '0;
    for (int l = 1; l <= leafLvl; l++) begin
      idx = va[48 - 9*l +: 9];
      a   = {tbl[47:12], idx, 3'b000};
      if (l == leafLvl) begin
        mem[a] = {16'b0, pa[47:12], 8'b0, s, c, (leafLvl == 4) ? 2'b11 : 2'b01};
        leafAddr = a;
      end else begin
        if (!mem.exists(a)) begin
          mem[a] = {16'b0, nextTbl[47:12], 12'h003};
          nextTbl = nextTbl + 48'h1000;
        end
        tbl = {mem[a][47:12], 12'h000};
      end
    end
  endtask

  function automatic logic [47:0] expPa(input logic [63:0] va, input logic [47:0] pa, input int lvl);
    logic [47:0] m;
    m = (lvl == 4) ? 48'hFFF : (lvl == 3) ? 48'h1F_FFFF : 48'h3FFF_FFFF;
    return (pa & ~m) | (va[47:0] & m);
  endfunction

  // driver: present a request, push its expectation once it will be taken
  task automatic send(input logic [1:0] ctx, input logic [63:0] va, input logic [47:0] pa,
                      input logic c, input logic s, input logic f, input int reads, input string tag);
    exp_t e;
    reqValid = 1; reqAsid = ctx; reqVa = va;
    while (!reqReady) @(negedge clk);
    e.asid = ctx; e.va = va; e.pa = pa; e.c = c; e.s = s; e.f = f; e.reads = reads; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 0;
    if (reads == 0)
      chk(rspValid === 1'b1, {tag, " one-cycle response"}, 64'(rspValid), 64'd1);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // memory responder: data one cycle after the read strobe
  logic        pend = 0;
  logic [47:0] pendAddr;
  initial forever begin
    @(negedge clk);
    memRspValid = 0;
    if (pend) begin
      memRspValid = 1;
      memRspData  = mem.exists(pendAddr) ? mem[pendAddr] : 64'h0;
      pend = 0;
    end
    if (memReqValid) begin
      pend = 1;
      pendAddr = memReqAddr;
    end
  end

  // monitor / scoreboard
  int rdCnt = 0;
  initial forever begin
    @(negedge clk);
    if (rstN && memReqValid) rdCnt++;
    if (rstN && rspValid) begin
      exp_t e;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected response actual va=%h expected none", rspVa);
      end else begin
        e = expQ.pop_front();
        if (rspAsid !== e.asid || rspVa !== e.va || rspPa !== e.pa || rspCacheable !== e.c ||
            rspShared !== e.s || rspFault !== e.f || rdCnt != e.reads) begin
          fails++;
          $display("FAIL %s actual asid=%0d va=%h pa=%h c=%b s=%b f=%b reads=%0d expected asid=%0d va=%h pa=%h c=%b s=%b f=%b reads=%0d",
                   e.tag, rspAsid, rspVa, rspPa, rspCacheable, rspShared, rspFault, rdCnt,
                   e.asid, e.va, e.pa, e.c, e.s, e.f, e.reads);
        end
      end
      rdCnt = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam logic [63:0] VA_A   = 64'h0000_0040_2003_5123;
  localparam logic [47:0] PA_A   = 48'h0000_ABCD_E000;
  localparam logic [47:0] PA_B   = 48'h0000_5555_5000;
  localparam logic [63:0] VA_1G  = 64'h0000_0080_5234_5678;
  localparam logic [47:0] PA_1G  = 48'h00C0_0000_0000;
  localparam logic [63:0] VA_2M  = 64'h0000_0100_0065_4321;
  localparam logic [63:0] VA_2MB = 64'h0000_0100_0071_0000;
  localparam logic [47:0] PA_2M  = 48'h0000_3A00_0000;

  initial begin
    logic [47:0] la;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1 reqReady in reset", 64'(reqReady), 64'd1);
    chk(rspValid === 1'b0, "R1 rspValid in reset", 64'(rspValid), 64'd0);
    chk(memReqValid === 1'b0, "R1 memReqValid in reset", 64'(memReqValid), 64'd0);
    rstN = 1;
    @(negedge clk);

    mapLeaf(2'd0, VA_A, PA_A, 1'b1, 1'b0, 4, la);
    mapLeaf(2'd1, VA_A, PA_B, 1'b0, 1'b0, 4, la);
    mapLeaf(2'd0, VA_1G, PA_1G, 1'b0, 1'b1, 2, la);
    mapLeaf(2'd0, VA_2M, PA_2M, 1'b1, 1'b1, 3, la);

    // R2 out-of-range addresses
    send(2'd0, 64'h0001_0000_0000_1000, 48'h0, 0, 0, 1, 0, "R2 bit48 fault");
    send(2'd1, 64'h8000_0000_0000_0000, 48'h0, 0, 0, 1, 0, "R2 bit63 fault");

    // R1 cold cache, R3/R4 four-level page walk, R12 port closed during walk
    send(2'd0, VA_A, expPa(VA_A, PA_A, 4), 1, 0, 0, 4, "R4 page walk R3 R1");
    chk(reqReady === 1'b0, "R12 reqReady low during walk", 64'(reqReady), 64'd0);
    drain();
    // R7 hit in same page
    send(2'd0, VA_A + 64'hA0, expPa(VA_A + 64'hA0, PA_A, 4), 1, 0, 0, 0, "R7 page hit");
    // R2 high bits beat a hit on the low bits
    send(2'd0, VA_A | 64'h0001_0000_0000_0000, 48'h0, 0, 0, 1, 0, "R2 over hit");
    drain();

    // R5 blocks, R9 block coverage
    send(2'd0, VA_1G, expPa(VA_1G, PA_1G, 2), 0, 1, 0, 2, "R5 1G block");
    drain();
    send(2'd0, VA_2M, expPa(VA_2M, PA_2M, 3), 1, 1, 0, 3, "R5 2M block");
    drain();
    send(2'd0, VA_2MB, expPa(VA_2MB, PA_2M, 3), 1, 1, 0, 0, "R9 2M block hit");
    send(2'd0, VA_1G + 64'h0ABC_0000, expPa(VA_1G + 64'h0ABC_0000, PA_1G, 2), 0, 1, 0, 0, "R9 1G block hit");
    drain();

    // R8 same VA in two spaces, interleaved
    send(2'd1, VA_A, expPa(VA_A, PA_B, 4), 0, 0, 0, 4, "R8 ctx1 walk");
    drain();
    send(2'd0, VA_A, expPa(VA_A, PA_A, 4), 1, 0, 0, 0, "R8 ctx0 hit");
    send(2'd1, VA_A, expPa(VA_A, PA_B, 4), 0, 0, 0, 0, "R8 ctx1 hit");
    send(2'd0, VA_A, expPa(VA_A, PA_A, 4), 1, 0, 0, 0, "R8 ctx0 hit again");
    drain();

    // R6 faults at each level
    send(2'd2, 64'h0000_0000_0000_3000, 48'h0, 0, 0, 1, 1, "R6 L1 empty");
    drain();
    mem[{base[2][47:12], 9'd16, 3'b000}] = 64'h1;
    send(2'd2, 64'h0000_0800_0000_0000, 48'h0, 0, 0, 1, 1, "R6 L1 type01");
    drain();
    mapLeaf(2'd2, 64'h0000_1000_0000_0000, 48'h0, 0, 0, 2, la);
    mem[la] = 64'h2;
    send(2'd2, 64'h0000_1000_0000_0000, 48'h0, 0, 0, 1, 2, "R6 L2 type10");
    drain();
    mapLeaf(2'd2, 64'h0000_0001_0020_3000, 48'h0, 0, 0, 4, la);
    mem[la] = 64'h1;
    send(2'd2, 64'h0000_0001_0020_3000, 48'h0, 0, 0, 1, 4, "R6 L4 type01");
    drain();

    // R10 invalidate space 1 only
    @(negedge clk);
    invValid = 1; invAsid = 2'd1;
    @(negedge clk);
    invValid = 0;
    send(2'd1, VA_A, expPa(VA_A, PA_B, 4), 0, 0, 0, 4, "R10 ctx1 rewalk");
    drain();
    send(2'd0, VA_A, expPa(VA_A, PA_A, 4), 1, 0, 0, 0, "R10 ctx0 still hits");
    drain();

    // R11 round-robin replacement in space 3
    for (int i = 0; i < 9; i++) begin
      mapLeaf(2'd3, 64'h0000_0000_7000_0000 + 64'(i) * 64'h1000,
              48'h0000_0800_0000 + 48'(i) * 48'h2000, 1'b0, 1'b1, 4, la);
    end
    for (int i = 0; i < 9; i++) begin
      send(2'd3, 64'h0000_0000_7000_0000 + 64'(i) * 64'h1000,
           48'h0000_0800_0000 + 48'(i) * 48'h2000, 0, 1, 0, 4, "R11 fill");
      drain();
    end
    send(2'd3, 64'h0000_0000_7000_1000, 48'h0000_0800_2000, 0, 1, 0, 0, "R11 second oldest hits");
    drain();
    send(2'd3, 64'h0000_0000_7000_0000, 48'h0000_0800_0000, 0, 1, 0, 4, "R11 oldest evicted");
    drain();

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule